// File: doc/BRIEF.md
# Vertex Attribute Fetch Unit

This block turns a draw command into a stream of per-component vertex attribute values. A draw starts with a pulse on one of two trigger inputs: one numbers vertices by a plain loop counter, the other reads each vertex number from an index array in memory. For every vertex, the unit walks the enabled attribute slots in order. It works out the byte address of each component, reads the raw value through a one-cycle synchronous memory port, and converts it to a 32-bit result. The result carries attribute, component and vertex tags and a valid strobe.

Attribute slots get their source offset and byte stride from a set of loaders. Each loader owns a contiguous run of slots. Every slot in a run shares the loader's stride. Each slot in the run starts where the previous slot's data ends. The slot table and all other configuration are captured when the draw is accepted, so software may reprogram the inputs while a draw runs. Integer sources are sign- or zero-extended to 32 bits. Float sources pass through unchanged and are flagged.

Top module: `vaf_top`

## Requirements
- R1: When idle with a non-zero `vtx_count_i`, a pulse on `draw_flat_i` alone starts a non-indexed draw. Vertex numbers run 0, 1, ... `vtx_count_i`-1, and `busy_o` is high in the next cycle.
- R2: A pulse on `draw_idx_i` starts an indexed draw, and it also wins when both triggers are high. Vertex i is read from `base_addr_i + idx_off_i + i` as one byte when `idx_wide_i`=0. When `idx_wide_i`=1 it is read from `base_addr_i + idx_off_i + 2*i` as a 16-bit little-endian value.
- R3: Loader l maps `ldr_ncomp_i[4l+:4]` slots (at most 12), taken from the 4-bit slot numbers at `ldr_map_i[(12l+c)*4+:4]` for c = 0, 1, .... The first mapped slot's source is `ldr_off_i[32l+:32]`. Each later slot's source adds the previous slot's size, which is element count times element size. All mapped slots take `ldr_stride_i[8l+:8]`. When loaders map the same slot, the higher-numbered loader wins. Unmapped slots have source 0 and stride 0.
- R4: A component's byte address is `base_addr_i + source + stride*vertex + component*element size`. The element size is 1 byte for format codes 0 and 1, 2 bytes for code 2, and 4 bytes for code 3.
- R5: The per-slot format is `slot_fmt_i[2s+:2]`. Code 0 is signed 8-bit, sign-extended. Code 1 is unsigned 8-bit, zero-extended. Code 2 is signed 16-bit, sign-extended. Code 3 is a 32-bit float, passed raw with `out_float_o`=1. `out_float_o` is 0 for the other codes.
- R6: For each vertex, slots 0 to `num_attr_i` are emitted in order. Each slot emits components 0 to `slot_elems_i[2s+:2]`, since both fields hold count minus one. Each output is tagged with `out_attr_o`, `out_comp_o` and `out_vtx_o`. `vtx_end_o` is high with the last component of each vertex.
- R7: A draw emits exactly `vtx_count_i` vertices. A trigger with `vtx_count_i`=0 produces no output and leaves `busy_o` low.
- R8: `busy_o` stays high from the cycle after an accepted trigger through the cycle of the final output, then falls. Triggers that arrive while busy are ignored.
- R9: All configuration inputs are captured when a draw is accepted. Changing them during the draw has no effect on it.
- R10: Each index and each component takes one memory read. `mem_rdata_i` returns bytes addr..addr+3 little-endian, one cycle after `mem_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| draw_flat_i | input | 1 | Trigger for a non-indexed draw |
| draw_idx_i | input | 1 | Trigger for an indexed draw |
| base_addr_i | input | ADDR_W | Base byte address for indices and attribute data |
| idx_off_i | input | ADDR_W | Offset of the index array from the base |
| idx_wide_i | input | 1 | 1 = 16-bit indices, 0 = 8-bit indices |
| vtx_count_i | input | CNT_W | Number of vertices in the draw |
| num_attr_i | input | SLOT_W | Highest slot number emitted (count minus one) |
| slot_fmt_i | input | 2*NUM_SLOT | Element format code per slot |
| slot_elems_i | input | 2*NUM_SLOT | Element count minus one per slot |
| ldr_off_i | input | ADDR_W*NUM_LDR | Data offset per loader |
| ldr_stride_i | input | STRIDE_W*NUM_LDR | Byte stride per loader |
| ldr_ncomp_i | input | MAPCNT_W*NUM_LDR | Number of slots mapped by each loader |
| ldr_map_i | input | SLOT_W*LDR_MAP*NUM_LDR | Slot numbers mapped by each loader |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read byte address |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| busy_o | output | 1 | Draw in progress |
| out_valid_o | output | 1 | Output component valid |
| out_data_o | output | 32 | Converted component value |
| out_float_o | output | 1 | Value is a raw 32-bit float |
| out_attr_o | output | SLOT_W | Attribute slot tag |
| out_comp_o | output | 2 | Component tag |
| out_vtx_o | output | CNT_W | Vertex number |
| vtx_end_o | output | 1 | Last component of the vertex |

## Verification
The hardest situation to reach from the ports is a reprogramming of every configuration input, together with a fresh trigger, while a draw is still running. The design must finish the draw with the old snapshot and must not start a second draw. The bench covers this with a disturbance option. A cycle after the draw starts, it pulses both triggers and randomizes the base, count, formats and loader offsets. It then compares every output against a stream it computed before the trigger. Overlapping loader mappings and 16-bit indices with a non-zero high byte are set up directly. Randomized draws cover the mix of formats and strides.

// File: rtl/vaf_pkg.sv
package vaf_pkg;

  typedef enum logic [1:0] {
    FMT_S8  = 2'd0,
    FMT_U8  = 2'd1,
    FMT_S16 = 2'd2,
    FMT_F32 = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDX_REQ,
    ST_IDX_WAIT,
    ST_CMP_REQ,
    ST_CMP_WAIT
  } state_e;

  // log2 of element size in bytes
  function automatic logic [1:0] size_shift(input logic [1:0] fmt);
    case (fmt)
      2'd0, 2'd1: return 2'd0;
      2'd2:       return 2'd1;
      default:    return 2'd2;
    endcase
  endfunction

  function automatic logic [4:0] slot_bytes(input logic [1:0] fmt, input logic [1:0] elems_m1);
    logic [4:0] n;
    n = {3'd0, elems_m1} + 5'd1;
    return n << size_shift(fmt);
  endfunction

endpackage

// File: rtl/vaf_slot_setup.sv
module vaf_slot_setup
  import vaf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_LDR  = 12,
  parameter int NUM_SLOT = 16,
  parameter int LDR_MAP  = 12,
  parameter int STRIDE_W = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOT),
  localparam int MAPCNT_W = $clog2(LDR_MAP + 1)
) (
  input  logic [2*NUM_SLOT-1:0]               slot_fmt_i,
  input  logic [2*NUM_SLOT-1:0]               slot_elems_i,
  input  logic [ADDR_W*NUM_LDR-1:0]           ldr_off_i,
  input  logic [STRIDE_W*NUM_LDR-1:0]         ldr_stride_i,
  input  logic [MAPCNT_W*NUM_LDR-1:0]         ldr_ncomp_i,
  input  logic [SLOT_W*LDR_MAP*NUM_LDR-1:0]   ldr_map_i,
  output logic [ADDR_W*NUM_SLOT-1:0]          src_o,
  output logic [STRIDE_W*NUM_SLOT-1:0]        stride_o
);

  logic [ADDR_W-1:0] run;
  logic [SLOT_W-1:0] sl;

  // Loaders applied in ascending order: a later loader overrides a shared slot.
  always_comb begin
    src_o    = '0;
    stride_o = '0;
    run      = '0;
    sl       = '0;
    for (int l = 0; l < NUM_LDR; l++) begin
      run = ldr_off_i[l*ADDR_W +: ADDR_W];
      for (int c = 0; c < LDR_MAP; c++) begin
        if (MAPCNT_W'(c) < ldr_ncomp_i[l*MAPCNT_W +: MAPCNT_W]) begin
          sl = ldr_map_i[(l*LDR_MAP + c)*SLOT_W +: SLOT_W];
          src_o[sl*ADDR_W +: ADDR_W]        = run;
          stride_o[sl*STRIDE_W +: STRIDE_W] = ldr_stride_i[l*STRIDE_W +: STRIDE_W];
          run = run + ADDR_W'(slot_bytes(slot_fmt_i[sl*2 +: 2], slot_elems_i[sl*2 +: 2]));
        end
      end
    end
  end

endmodule

// File: rtl/vaf_addr_gen.sv
module vaf_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 8
) (
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [CNT_W-1:0]    vtx_i,
  input  logic [1:0]          comp_i,
  input  logic [1:0]          shift_i,
  input  logic [ADDR_W-1:0]   idx_off_i,
  input  logic                idx_wide_i,
  input  logic [CNT_W-1:0]    loop_i,
  output logic [ADDR_W-1:0]   comp_addr_o,
  output logic [ADDR_W-1:0]   idx_addr_o
);

  localparam int PROD_W = STRIDE_W + CNT_W;

  logic [PROD_W-1:0] prod;
  logic [4:0]        comp_off;

  assign prod     = {{CNT_W{1'b0}}, stride_i} * {{STRIDE_W{1'b0}}, vtx_i};
  assign comp_off = {3'd0, comp_i} << shift_i;

  assign comp_addr_o = base_i + src_i + ADDR_W'(prod) + ADDR_W'(comp_off);
  assign idx_addr_o  = base_i + idx_off_i +
                       (idx_wide_i ? ADDR_W'({loop_i, 1'b0}) : ADDR_W'(loop_i));

endmodule

// File: rtl/vaf_convert.sv
module vaf_convert
  import vaf_pkg::*;
(
  input  logic [1:0]  fmt_i,
  input  logic [31:0] raw_i,
  output logic [31:0] data_o,
  output logic        is_float_o
);

  always_comb begin
    is_float_o = 1'b0;
    case (fmt_e'(fmt_i))
      FMT_S8:  data_o = {{24{raw_i[7]}}, raw_i[7:0]};
      FMT_U8:  data_o = {24'd0, raw_i[7:0]};
      FMT_S16: data_o = {{16{raw_i[15]}}, raw_i[15:0]};
      default: begin
        data_o     = raw_i;
        is_float_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/vaf_top.sv
module vaf_top
  import vaf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int NUM_LDR  = 12,
  parameter int NUM_SLOT = 16,
  parameter int LDR_MAP  = 12,
  parameter int STRIDE_W = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOT),
  localparam int MAPCNT_W = $clog2(LDR_MAP + 1)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               draw_flat_i,
  input  logic                               draw_idx_i,
  input  logic [ADDR_W-1:0]                  base_addr_i,
  input  logic [ADDR_W-1:0]                  idx_off_i,
  input  logic                               idx_wide_i,
  input  logic [CNT_W-1:0]                   vtx_count_i,
  input  logic [SLOT_W-1:0]                  num_attr_i,
  input  logic [2*NUM_SLOT-1:0]              slot_fmt_i,
  input  logic [2*NUM_SLOT-1:0]              slot_elems_i,
  input  logic [ADDR_W*NUM_LDR-1:0]          ldr_off_i,
  input  logic [STRIDE_W*NUM_LDR-1:0]        ldr_stride_i,
  input  logic [MAPCNT_W*NUM_LDR-1:0]        ldr_ncomp_i,
  input  logic [SLOT_W*LDR_MAP*NUM_LDR-1:0]  ldr_map_i,
  output logic                               mem_req_o,
  output logic [ADDR_W-1:0]                  mem_addr_o,
  input  logic [31:0]                        mem_rdata_i,
  output logic                               busy_o,
  output logic                               out_valid_o,
  output logic [31:0]                        out_data_o,
  output logic                               out_float_o,
  output logic [SLOT_W-1:0]                  out_attr_o,
  output logic [1:0]                         out_comp_o,
  output logic [CNT_W-1:0]                   out_vtx_o,
  output logic                               vtx_end_o
);

  state_e                        state_q;
  logic                          indexed_q, wide_q;
  logic [ADDR_W-1:0]             base_q, idx_off_q;
  logic [CNT_W-1:0]              count_q, loop_q, vtx_q;
  logic [SLOT_W-1:0]             nattr_q, attr_q;
  logic [1:0]                    comp_q;
  logic [2*NUM_SLOT-1:0]         fmt_q, elems_q;
  logic [ADDR_W*NUM_SLOT-1:0]    src_q, setup_src;
  logic [STRIDE_W*NUM_SLOT-1:0]  stride_q, setup_stride;

  logic [1:0]          fmt_cur, elems_cur;
  logic [ADDR_W-1:0]   src_cur, comp_addr, idx_addr;
  logic [STRIDE_W-1:0] stride_cur;
  logic                trig, last_comp, last_attr, last_vtx;

  vaf_slot_setup #(
    .ADDR_W(ADDR_W), .NUM_LDR(NUM_LDR), .NUM_SLOT(NUM_SLOT),
    .LDR_MAP(LDR_MAP), .STRIDE_W(STRIDE_W)
  ) u_setup (
    .slot_fmt_i   (slot_fmt_i),
    .slot_elems_i (slot_elems_i),
    .ldr_off_i    (ldr_off_i),
    .ldr_stride_i (ldr_stride_i),
    .ldr_ncomp_i  (ldr_ncomp_i),
    .ldr_map_i    (ldr_map_i),
    .src_o        (setup_src),
    .stride_o     (setup_stride)
  );

  assign fmt_cur    = fmt_q[attr_q*2 +: 2];
  assign elems_cur  = elems_q[attr_q*2 +: 2];
  assign src_cur    = src_q[attr_q*ADDR_W +: ADDR_W];
  assign stride_cur = stride_q[attr_q*STRIDE_W +: STRIDE_W];

  vaf_addr_gen #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)
  ) u_addr (
    .base_i      (base_q),
    .src_i       (src_cur),
    .stride_i    (stride_cur),
    .vtx_i       (vtx_q),
    .comp_i      (comp_q),
    .shift_i     (size_shift(fmt_cur)),
    .idx_off_i   (idx_off_q),
    .idx_wide_i  (wide_q),
    .loop_i      (loop_q),
    .comp_addr_o (comp_addr),
    .idx_addr_o  (idx_addr)
  );

  vaf_convert u_conv (
    .fmt_i      (fmt_cur),
    .raw_i      (mem_rdata_i),
    .data_o     (out_data_o),
    .is_float_o (out_float_o)
  );

  assign trig      = (draw_flat_i || draw_idx_i) && (vtx_count_i != '0);
  assign last_comp = (comp_q == elems_cur);
  assign last_attr = (attr_q == nattr_q);
  assign last_vtx  = (loop_q == count_q - 1'b1);

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_IDX_REQ) || (state_q == ST_CMP_REQ);
  assign mem_addr_o  = (state_q == ST_IDX_REQ) ? idx_addr : comp_addr;
  assign out_valid_o = (state_q == ST_CMP_WAIT);
  assign vtx_end_o   = out_valid_o && last_comp && last_attr;
  assign out_attr_o  = attr_q;
  assign out_comp_o  = comp_q;
  assign out_vtx_o   = vtx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      indexed_q <= 1'b0;
      wide_q    <= 1'b0;
      base_q    <= '0;
      idx_off_q <= '0;
      count_q   <= '0;
      loop_q    <= '0;
      vtx_q     <= '0;
      nattr_q   <= '0;
      attr_q    <= '0;
      comp_q    <= '0;
      fmt_q     <= '0;
      elems_q   <= '0;
      src_q     <= '0;
      stride_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (trig) begin
          // snapshot of all configuration; indexed trigger has priority
          indexed_q <= draw_idx_i;
          wide_q    <= idx_wide_i;
          base_q    <= base_addr_i;
          idx_off_q <= idx_off_i;
          count_q   <= vtx_count_i;
          nattr_q   <= num_attr_i;
          fmt_q     <= slot_fmt_i;
          elems_q   <= slot_elems_i;
          src_q     <= setup_src;
          stride_q  <= setup_stride;
          loop_q    <= '0;
          vtx_q     <= '0;
          attr_q    <= '0;
          comp_q    <= '0;
          state_q   <= draw_idx_i ? ST_IDX_REQ : ST_CMP_REQ;
        end
        ST_IDX_REQ:  state_q <= ST_IDX_WAIT;
        ST_IDX_WAIT: begin
          vtx_q   <= wide_q ? CNT_W'(mem_rdata_i[15:0]) : CNT_W'(mem_rdata_i[7:0]);
          state_q <= ST_CMP_REQ;
        end
        ST_CMP_REQ:  state_q <= ST_CMP_WAIT;
        ST_CMP_WAIT: begin
          if (!last_comp) begin
            comp_q  <= comp_q + 2'd1;
            state_q <= ST_CMP_REQ;
          end else begin
            comp_q <= '0;
            if (!last_attr) begin
              attr_q  <= attr_q + 1'b1;
              state_q <= ST_CMP_REQ;
            end else begin
              attr_q <= '0;
              if (last_vtx) begin
                state_q <= ST_IDLE;
              end else begin
                loop_q  <= loop_q + 1'b1;
                vtx_q   <= loop_q + 1'b1;
                state_q <= indexed_q ? ST_IDX_REQ : ST_CMP_REQ;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vaf_checker.sv
module vaf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             draw_flat_i,
  input logic             draw_idx_i,
  input logic [CNT_W-1:0] vtx_count_i,
  input logic             mem_req_o,
  input logic [31:0]      mem_rdata_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic [31:0]      out_data_o,
  input logic             out_float_o,
  input logic             vtx_end_o
);

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (draw_flat_i || draw_idx_i) && vtx_count_i != '0) |=> busy_o); // R1

  AST_ZERO_COUNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && vtx_count_i == '0) |=> !busy_o); // R7

  AST_VALID_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> busy_o); // R8

  AST_BUSY_FALL_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(vtx_end_o)); // R8

  AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R10

  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(mem_req_o)); // R10

  AST_END_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtx_end_o |-> out_valid_o); // R6

  AST_FLOAT_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_float_o) |-> (out_data_o == mem_rdata_i)); // R5

endmodule

bind vaf_top vaf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .draw_flat_i (draw_flat_i),
  .draw_idx_i  (draw_idx_i),
  .vtx_count_i (vtx_count_i),
  .mem_req_o   (mem_req_o),
  .mem_rdata_i (mem_rdata_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_float_o (out_float_o),
  .vtx_end_o   (vtx_end_o)
);

// File: tb/tb_vaf_top.sv
`timescale 1ns/1ps
module tb_vaf_top;
  localparam int NL = 12, NS = 16, LM = 12, AW = 32, CW = 16, SW = 8;
  localparam int SLW = 4, MCW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 draw_flat = 0, draw_idx = 0, wide = 0;
  logic [AW-1:0]        base = 0, ioff = 0;
  logic [CW-1:0]        cnt = 0;
  logic [SLW-1:0]       nattr = 0;
  logic [2*NS-1:0]      sfmt = 0, selems = 0;
  logic [AW*NL-1:0]     loff = 0;
  logic [SW*NL-1:0]     lstr = 0;
  logic [MCW*NL-1:0]    lnc = 0;
  logic [SLW*LM*NL-1:0] lmap = 0;
  logic                 mem_req, busy, out_valid, out_float, vtx_end;
  logic [AW-1:0]        mem_addr;
  logic [31:0]          mem_rdata = 0, out_data;
  logic [SLW-1:0]       out_attr;
  logic [1:0]           out_comp;
  logic [CW-1:0]        out_vtx;

  vaf_top dut (
    .clk_i(clk), .rst_ni(rst_n), .draw_flat_i(draw_flat), .draw_idx_i(draw_idx),
    .base_addr_i(base), .idx_off_i(ioff), .idx_wide_i(wide), .vtx_count_i(cnt),
    .num_attr_i(nattr), .slot_fmt_i(sfmt), .slot_elems_i(selems),
    .ldr_off_i(loff), .ldr_stride_i(lstr), .ldr_ncomp_i(lnc), .ldr_map_i(lmap),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_float_o(out_float), .out_attr_o(out_attr), .out_comp_o(out_comp),
    .out_vtx_o(out_vtx), .vtx_end_o(vtx_end)
  );

  logic [7:0] mem [0:4095];

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[12'(a + 32'd3)], mem[12'(a + 32'd2)], mem[12'(a + 32'd1)], mem[12'(a)]};
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= rd32(mem_addr);

  int n_chk = 0, n_fail = 0;
  logic [31:0] e_data [0:1023];
  logic [3:0]  e_attr [0:1023];
  logic [1:0]  e_comp [0:1023];
  logic [15:0] e_vtx  [0:1023];
  logic        e_end  [0:1023];
  logic        e_flt  [0:1023];
  int wr_p = 0, rd_p = 0;
  bit cur_idx = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int esz(input logic [1:0] f);
    return (f == 2'd3) ? 4 : (f == 2'd2) ? 2 : 1;
  endfunction

  // expected stream from the requirements, using the memory contents
  task automatic build_expected(input bit idx);
    logic [31:0] src [NS];
    logic [7:0]  str [NS];
    logic [31:0] run, a, v, raw, d;
    int sl, f, ne;
    wr_p = 0; rd_p = 0;
    for (int s = 0; s < NS; s++) begin src[s] = 0; str[s] = 0; end
    for (int l = 0; l < NL; l++) begin
      run = loff[l*AW +: AW];
      for (int c = 0; c < LM; c++) begin
        if (c < int'(lnc[l*MCW +: MCW])) begin
          sl = int'(lmap[(l*LM + c)*SLW +: SLW]);
          src[sl] = run;
          str[sl] = lstr[l*SW +: SW];
          run = run + 32'((int'(selems[sl*2 +: 2]) + 1) * esz(sfmt[sl*2 +: 2]));
        end
      end
    end
    for (int i = 0; i < int'(cnt); i++) begin
      if (idx) begin
        a = base + ioff + (wide ? 32'(2*i) : 32'(i));
        v = wide ? {16'd0, mem[12'(a + 32'd1)], mem[12'(a)]} : {24'd0, mem[12'(a)]};
      end else v = 32'(i);
      for (int at = 0; at <= int'(nattr); at++) begin
        f  = int'(sfmt[at*2 +: 2]);
        ne = int'(selems[at*2 +: 2]);
        for (int c = 0; c <= ne; c++) begin
          a = base + src[at] + {24'd0, str[at]} * v + 32'(c * esz(2'(f)));
          raw = rd32(a);
          case (f)
            0: d = {{24{raw[7]}}, raw[7:0]};
            1: d = {24'd0, raw[7:0]};
            2: d = {{16{raw[15]}}, raw[15:0]};
            default: d = raw;
          endcase
          e_data[wr_p] = d;
          e_attr[wr_p] = 4'(at);
          e_comp[wr_p] = 2'(c);
          e_vtx[wr_p]  = v[15:0];
          e_end[wr_p]  = (at == int'(nattr)) && (c == ne);
          e_flt[wr_p]  = (f == 3);
          wr_p++;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd_p >= wr_p) chk(1'b0, "R7", "unexpected output", 32'(rd_p), 32'(wr_p));
      else begin
        chk(out_data == e_data[rd_p], "R3 R4 R5", "data", out_data, e_data[rd_p]);
        chk(out_attr == e_attr[rd_p] && out_comp == e_comp[rd_p], "R6", "attr/comp tag",
            {out_attr, 2'b0, out_comp}, {e_attr[rd_p], 2'b0, e_comp[rd_p]});
        if (cur_idx) chk(out_vtx == e_vtx[rd_p], "R2", "indexed vertex", 32'(out_vtx), 32'(e_vtx[rd_p]));
        else         chk(out_vtx == e_vtx[rd_p], "R1", "flat vertex", 32'(out_vtx), 32'(e_vtx[rd_p]));
        chk(vtx_end == e_end[rd_p], "R6", "vertex end", 32'(vtx_end), 32'(e_end[rd_p]));
        chk(out_float == e_flt[rd_p], "R5", "float flag", 32'(out_float), 32'(e_flt[rd_p]));
        rd_p++;
      end
    end
  end

  task automatic clear_ldr();
    lnc = '0; lmap = '0; loff = '0; lstr = '0;
  endtask

  task automatic set_ldr(input int l, input int off, input int stride, input int n);
    loff[l*AW +: AW]  = 32'(off);
    lstr[l*SW +: SW]  = 8'(stride);
    lnc[l*MCW +: MCW] = 4'(n);
  endtask

  task automatic set_map(input int l, input int c, input int s);
    lmap[(l*LM + c)*SLW +: SLW] = 4'(s);
  endtask

  task automatic set_slot(input int s, input int f, input int ne_m1);
    sfmt[s*2 +: 2]   = 2'(f);
    selems[s*2 +: 2] = 2'(ne_m1);
  endtask

  task automatic rand_cfg();
    int nl;
    base  = $urandom_range(0, 4095);
    ioff  = $urandom_range(0, 255);
    wide  = 1'($urandom_range(0, 1));
    cnt   = 16'($urandom_range(1, 6));
    nattr = 4'($urandom_range(0, 15));
    sfmt  = $urandom;
    selems = $urandom;
    clear_ldr();
    nl = $urandom_range(1, NL);
    for (int l = 0; l < nl; l++) begin
      set_ldr(l, $urandom_range(0, 511), $urandom_range(0, 63),
              ($urandom_range(0, 7) == 0) ? 12 : $urandom_range(0, 4));
      for (int c = 0; c < LM; c++) set_map(l, c, $urandom_range(0, NS-1));
    end
  endtask

  task automatic run_draw(input bit tf, input bit ti, input bit disturb);
    cur_idx = ti;
    build_expected(ti);
    @(negedge clk); draw_flat = tf; draw_idx = ti;
    @(negedge clk); draw_flat = 0; draw_idx = 0;
    if (cnt == 0) begin
      chk(!busy, "R7", "busy on zero count", 32'(busy), 0);
      repeat (4) @(negedge clk);
      chk(rd_p == 0, "R7", "outputs on zero count", 32'(rd_p), 0);
      return;
    end
    chk(busy, "R8", "busy after trigger", 32'(busy), 1);
    if (disturb) begin
      @(negedge clk);
      draw_flat = 1; draw_idx = 1;
      base = $urandom; cnt = 16'($urandom_range(1, 9)); sfmt = $urandom; selems = $urandom;
      nattr = 4'($urandom); loff = {NL{$urandom}}; wide = ~wide;
      @(negedge clk); draw_flat = 0; draw_idx = 0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy, "R8", "busy dropped and stayed low", 32'(busy), 0);
    if (disturb) chk(rd_p == wr_p, "R9", "outputs under reprogramming", 32'(rd_p), 32'(wr_p));
    else         chk(rd_p == wr_p, "R7", "output count", 32'(rd_p), 32'(wr_p));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired act=%h exp=%h", busy, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1957));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!busy && !out_valid, "R8", "reset idle", {30'd0, busy, out_valid}, 0);
    chk(!mem_req, "R10", "no request after reset", 32'(mem_req), 0);

    // zero count: nothing happens
    clear_ldr(); set_ldr(0, 0, 4, 1); set_map(0, 0, 0); set_slot(0, 1, 0);
    nattr = 0; base = 32'h40; cnt = 0;
    run_draw(1, 0, 0);

    // flat draw, one slot per format, several components
    clear_ldr(); base = 32'h200; cnt = 3; nattr = 3;
    set_slot(0, 0, 3); set_slot(1, 1, 1); set_slot(2, 2, 2); set_slot(3, 3, 3);
    set_ldr(0, 16, 40, 4);
    set_map(0, 0, 0); set_map(0, 1, 1); set_map(0, 2, 2); set_map(0, 3, 3);
    run_draw(1, 0, 0);

    // both triggers: indexed wins, 8-bit indices
    ioff = 32'h80; wide = 0;
    mem[12'h280] = 8'd5; mem[12'h281] = 8'd0; mem[12'h282] = 8'd200;
    run_draw(1, 1, 0);

    // 16-bit indices with non-zero high byte
    wide = 1;
    mem[12'h280] = 8'h02; mem[12'h281] = 8'h01;
    mem[12'h282] = 8'h00; mem[12'h283] = 8'h00;
    mem[12'h284] = 8'h07; mem[12'h285] = 8'h00;
    run_draw(0, 1, 0);

    // overlapping loaders: loader 3 overrides slot 1, slot 2 left unmapped
    clear_ldr(); nattr = 2; cnt = 2;
    set_slot(0, 2, 1); set_slot(1, 0, 2); set_slot(2, 1, 0);
    set_ldr(0, 8, 12, 2); set_map(0, 0, 0); set_map(0, 1, 1);
    set_ldr(3, 100, 20, 1); set_map(3, 0, 1);
    run_draw(1, 0, 0);

    // reprogramming and retrigger while busy
    rand_cfg();
    run_draw(0, 1, 1);

    for (int k = 0; k < 40; k++) begin
      bit ti;
      rand_cfg();
      ti = 1'($urandom_range(0, 1));
      run_draw(~ti, ti, ($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule